// File: doc/BRIEF.md
# Cascadable serial configuration memory

This block is the read side of a one-bit-wide serial memory that feeds a configuration bitstream to a loader. The memory holds a parameterised number of bits and shows one of them at a time on a data output. An internal address counter moves on by one at each rising clock edge while the device is enabled. The tristate output pin is modelled as a data bit plus a drive-enable. While the output is not driven, the data bit reads as 0, so several devices can share one line by OR-ing their data bits.

A combined reset/output-enable input holds the counter at zero and silences the output. A parameter picks its active level. A chip-enable input, active low, gates both counting and output. When the last bit has been read, the next enabled clock edge moves the device past its highest address. From then on it stops counting, releases the data line and pulls its chip-enable output low. That output drives the chip-enable input of the next device, so a chain of devices holds one long continuous stream. Real capacities run into the hundreds of thousands of bits and are reached through the depth parameter.

The contents are fixed at elaboration and computed from a seed parameter. The bit at address a is the XOR of all 32 bits of (a XOR seed), with a and seed taken as 32-bit values.

Top module: `cfgSerialMem`

## Requirements
- R1: While reset is active, the address is zero, the data output is not driven (dataDrive=0, dataOut=0) and ceoN is 1.
- R2: With RST_ACTIVE_HIGH=1, rstOe=1 means reset and rstOe=0 means enabled. With RST_ACTIVE_HIGH=0, the levels are swapped.
- R3: While ceN=1, the output is not driven whatever the level of rstOe, and clock edges leave the address unchanged. When ceN returns to 0, the same bit as before is presented.
- R4: After reset is released, bit 0 is presented. Each rising edge with ceN=0, reset inactive and the address below DEPTH-1 advances the address by one, and the new bit appears after that edge. The bit at address a is the XOR of all 32 bits of (a XOR SEED).
- R5: The first enabled edge after bit DEPTH-1 has been presented sets a past-end state. In that state dataDrive=0 and ceoN=0. Before that state is reached, ceoN=1 whenever the device drives.
- R6: The past-end state is sticky. Further edges change nothing, and while it holds, ceoN follows ceN.
- R7: Only reset leaves the past-end state. Reset forces ceoN to 1 and keeps it there, and after release the device presents bit 0 again.
- R8: In a chain where ceoN of one device drives ceN of the next, the shared line carries both bit sequences back to back with no gap, and two devices never drive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; state changes on its rising edge |
| rstOe | input | 1 | Reset/output-enable; active level set by RST_ACTIVE_HIGH |
| ceN | input | 1 | Chip enable, active low |
| dataOut | output | 1 | Current bit, 0 while not driven |
| dataDrive | output | 1 | High while the data output would be driven |
| ceoN | output | 1 | Chip-enable output to the next device, low once past the end |

## Verification
The edge that ends one device's stream is the same edge that hands the line to the next device. In that cycle, one device's last-bit read and end detection coincide with the other device's first bit going onto the line. The bench chains two instances with different seeds and opposite reset polarity and reads the full stream through that edge. It then judges the shared line bit by bit against both expected sequences. In every cycle it also checks that no two drive enables are high together.

// File: rtl/cfgMemPkg.sv
package cfgMemPkg;

  // strobes from control to datapath, valid for one clock edge
  typedef struct packed {
    logic step;    // advance address and load the next bit
    logic finish;  // last address has been consumed
  } ctlStrobes_t;

  // content rule: parity of (address xor seed)
  function automatic logic contentBit(input logic [31:0] seed,
                                      input logic [31:0] addr);
    return ^(addr ^ seed);
  endfunction

endpackage

// File: rtl/cfgMemPath.sv
module cfgMemPath
  import cfgMemPkg::*;
#(
  parameter int          DEPTH = 48,
  parameter logic [31:0] SEED  = 32'h0,
  parameter int          AW    = 6
) (
  input  logic          clk,
  input  logic          resetActive,
  input  ctlStrobes_t   strb,
  output logic [AW-1:0] curAddr,
  output logic          atLast,
  output logic          dataBit
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  function automatic logic [DEPTH-1:0] buildContent();
    logic [DEPTH-1:0] v;
    for (int i = 0; i < DEPTH; i++) v[i] = contentBit(SEED, 32'(i));
    return v;
  endfunction

  localparam logic [DEPTH-1:0] CONTENT = buildContent();

  logic [AW-1:0] nextAddr;
  assign nextAddr = curAddr + AW'(1);
  assign atLast   = (curAddr == LAST_ADDR);

  always_ff @(posedge clk or posedge resetActive) begin
    if (resetActive) begin
      curAddr <= '0;
      dataBit <= CONTENT[0];
    end else if (strb.step) begin
      curAddr <= nextAddr;
      dataBit <= CONTENT[nextAddr];
    end
  end

endmodule

// File: rtl/cfgMemCtrl.sv
module cfgMemCtrl
  import cfgMemPkg::*;
(
  input  logic        clk,
  input  logic        resetActive,
  input  logic        ceN,
  input  logic        atLast,
  output ctlStrobes_t strb,
  output logic        pastTc,
  output logic        dataDrive,
  output logic        ceoN
);

  logic active;
  assign active = !resetActive && !ceN;

  always_comb begin
    strb.step   = active && !pastTc && !atLast;
    strb.finish = active && !pastTc && atLast;
  end

  always_ff @(posedge clk or posedge resetActive) begin
    if (resetActive) pastTc <= 1'b0;
    else if (strb.finish) pastTc <= 1'b1;
  end

  assign dataDrive = active && !pastTc;
  assign ceoN      = !(active && pastTc);

endmodule

// File: rtl/cfgSerialMem.sv
module cfgSerialMem
  import cfgMemPkg::*;
#(
  parameter int          DEPTH           = 48,
  parameter bit          RST_ACTIVE_HIGH = 1'b1,
  parameter logic [31:0] SEED            = 32'h0
) (
  input  logic clk,
  input  logic rstOe,
  input  logic ceN,
  output logic dataOut,
  output logic dataDrive,
  output logic ceoN
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          resetActive;
  ctlStrobes_t   strb;
  logic [AW-1:0] curAddr;
  logic          atLast;
  logic          dataBit;
  logic          pastTc;

  generate
    if (RST_ACTIVE_HIGH) begin : g_rstHigh
      assign resetActive = rstOe;
    end else begin : g_rstLow
      assign resetActive = !rstOe;
    end
  endgenerate

  cfgMemCtrl u_ctrl (
    .clk        (clk),
    .resetActive(resetActive),
    .ceN        (ceN),
    .atLast     (atLast),
    .strb       (strb),
    .pastTc     (pastTc),
    .dataDrive  (dataDrive),
    .ceoN       (ceoN)
  );

  cfgMemPath #(.DEPTH(DEPTH), .SEED(SEED), .AW(AW)) u_path (
    .clk        (clk),
    .resetActive(resetActive),
    .strb       (strb),
    .curAddr    (curAddr),
    .atLast     (atLast),
    .dataBit    (dataBit)
  );

  assign dataOut = dataBit & dataDrive;

endmodule

// File: rtl/cfgSerialMemChk.sv
module cfgSerialMemChk #(
  parameter int DEPTH           = 48,
  parameter bit RST_ACTIVE_HIGH = 1'b1,
  parameter int AW              = 6
) (
  input logic          clk,
  input logic          rstOe,
  input logic          ceN,
  input logic          dataOut,
  input logic          dataDrive,
  input logic          ceoN,
  input logic [AW-1:0] curAddr,
  input logic          pastTc
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic rstAct;
  assign rstAct = RST_ACTIVE_HIGH ? rstOe : !rstOe;

  // R1: reset silences the device and parks the address
  always @(negedge clk) begin
    if (rstAct) begin
      assert_reset_quiet_R1: assert (!dataDrive && ceoN && !dataOut && curAddr == '0)
        else $error("reset state violated");
    end
  end

  // R3: disabled device does not move
  assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (rstAct)
    ceN |=> ($stable(curAddr) && $stable(pastTc)));

  // R4: enabled read steps the address by one
  assert_step_R4: assert property (@(posedge clk) disable iff (rstAct)
    (!ceN && dataDrive && curAddr != LAST_ADDR) |=> (curAddr == $past(curAddr) + AW'(1)));

  // R5: never drive data while handing the chain on
  assert_exclusive_R5: assert property (@(posedge clk) disable iff (rstAct)
    dataDrive |-> ceoN);

  // R6: past-end state is sticky and freezes the address
  assert_sticky_R6: assert property (@(posedge clk) disable iff (rstAct)
    pastTc |=> (pastTc && $stable(curAddr)));

endmodule

bind cfgSerialMem cfgSerialMemChk #(
  .DEPTH(DEPTH), .RST_ACTIVE_HIGH(RST_ACTIVE_HIGH), .AW(AW)
) u_chk (
  .clk      (clk),
  .rstOe    (rstOe),
  .ceN      (ceN),
  .dataOut  (dataOut),
  .dataDrive(dataDrive),
  .ceoN     (ceoN),
  .curAddr  (curAddr),
  .pastTc   (pastTc)
);

// File: tb/cfgSerialMem_tb.sv
`timescale 1ns/1ps
module cfgSerialMem_tb;

  localparam int          DEPTH = 48;
  localparam logic [31:0] SEED0 = 32'h0;
  localparam logic [31:0] SEED1 = 32'h5;

  logic clk = 1'b0;
  logic rst;
  logic ceN;
  logic d0, drv0, ceo0;
  logic d1, drv1, ceo1;
  logic bus;

  int tests = 0;
  int fails = 0;

  always #4 clk = !clk;

  // first device: active-high reset
  cfgSerialMem #(.DEPTH(DEPTH), .RST_ACTIVE_HIGH(1'b1), .SEED(SEED0)) u_dut (
    .clk(clk), .rstOe(rst), .ceN(ceN),
    .dataOut(d0), .dataDrive(drv0), .ceoN(ceo0));

  // second device: active-low reset, enabled by the first
  cfgSerialMem #(.DEPTH(DEPTH), .RST_ACTIVE_HIGH(1'b0), .SEED(SEED1)) u_nxt (
    .clk(clk), .rstOe(!rst), .ceN(ceo0),
    .dataOut(d1), .dataDrive(drv1), .ceoN(ceo1));

  assign bus = d0 | d1;

  function automatic logic expBit(input logic [31:0] seed, input int a);
    return ^(32'(a) ^ seed);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic testReset();
    rst = 1'b1; ceN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 dut drive", 32'(drv0), 0);
    check("R1 dut ceo", 32'(ceo0), 1);
    check("R1 dut data", 32'(d0), 0);
    check("R2 low-polarity device held", 32'(drv1), 0);
    check("R2 low-polarity ceo", 32'(ceo1), 1);
  endtask

  task automatic testDisabled();
    ceN = 1'b1; rst = 1'b0;
    repeat (4) begin
      @(negedge clk);
      check("R3 disabled no drive", 32'(drv0), 0);
      check("R3 disabled ceo", 32'(ceo0), 1);
    end
    ceN = 1'b0;
    #1;
    check("R3 address held, drive", 32'(drv0), 1);
    check("R4 bit 0 first", 32'(bus), 32'(expBit(SEED0, 0)));
  endtask

  task automatic testFirstDevice();
    for (int k = 0; k < DEPTH; k++) begin
      if (k > 0) @(negedge clk);
      check("R4 dut bit", 32'(bus), 32'(expBit(SEED0, k)));
      check("R5 dut ceo before end", 32'(ceo0), 1);
      check("R8 only dut drives", 32'({drv0, drv1}), 32'b10);
      if (k == 20) begin
        ceN = 1'b1;
        repeat (3) begin
          @(negedge clk);
          check("R3 pause no drive", 32'(drv0), 0);
        end
        ceN = 1'b0;
        #1;
        check("R3 resume same bit", 32'(bus), 32'(expBit(SEED0, 20)));
      end
    end
  endtask

  task automatic testHandOver();
    @(negedge clk);
    check("R5 dut released", 32'(drv0), 0);
    check("R5 dut ceo low", 32'(ceo0), 0);
    for (int k = 0; k < DEPTH; k++) begin
      if (k > 0) @(negedge clk);
      check("R8 nxt bit", 32'(bus), 32'(expBit(SEED1, k)));
      check("R8 only nxt drives", 32'({drv0, drv1}), 32'b01);
    end
    @(negedge clk);
    check("R5 nxt released", 32'(drv1), 0);
    check("R5 nxt ceo low", 32'(ceo1), 0);
  endtask

  task automatic testSticky();
    repeat (5) @(negedge clk);
    check("R6 sticky dut", 32'({drv0, ceo0}), 0);
    check("R6 sticky nxt", 32'({drv1, ceo1}), 0);
    ceN = 1'b1;
    #1;
    check("R6 ceo follows ce high", 32'(ceo0), 1);
    check("R6 chain released", 32'({drv1, ceo1}), 32'b01);
    @(negedge clk);
    ceN = 1'b0;
    #1;
    check("R6 ceo follows ce low", 32'(ceo0), 0);
    check("R6 no data after end", 32'(drv0), 0);
  endtask

  task automatic testRearm();
    rst = 1'b1;
    #1;
    check("R7 reset raises ceo", 32'(ceo0), 1);
    check("R7 nxt reset", 32'({drv1, ceo1}), 32'b01);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R7 ceo stays high", 32'(ceo0), 1);
    check("R7 restart bit 0", 32'({drv0, bus}), 32'({1'b1, expBit(SEED0, 0)}));
    @(negedge clk);
    check("R7 restart bit 1", 32'(bus), 32'(expBit(SEED0, 1)));
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; ceN = 1'b0;
    testReset();
    testDisabled();
    testFirstDevice();
    testHandOver();
    testSticky();
    testRearm();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule